// File: doc/BRIEF.md
# Undo-Log Recovery for an Eagerly Written Register File

This block pairs a small register file with a circular undo log. The register file takes each result the moment its instruction completes, so later readers always see the newest value. To keep exceptions precise, each instruction takes a log slot at decode, in program order. When it completes, the value its destination held just before the write is copied into that slot. The oldest instruction then retires in one of two ways. If it is clean, its slot is dropped and the register file is left alone. If it has an exception, the log is walked from the youngest slot back to the oldest. Each saved value is written back in turn, and at the end the register file holds the state from before the faulting instruction.

A mispredicted branch uses the same rewind, but stops at the branch. Only the slots younger than the branch are undone, and the slot after the branch becomes the next allocation point. Each rewind visits one slot per cycle and raises a busy flag for exactly that many cycles. While busy is high, allocation, completion and retirement are all refused. A slot whose instruction never completed, or that has no destination register, holds no saved value: it is visited and released without a write. For results to roll back correctly, producers of the same register must complete in program order, and the environment guarantees this.

Top module: `hb_undo_log`

## Requirements
- R1: Slots are handed out in program order. `alloc_tag` shows the next slot index, which increases by one per accepted allocation modulo 8. With all 8 slots occupied, `alloc_ready` is 0 and an allocation request leaves `alloc_tag` unchanged.
- R2: A completion writes its data into its destination register at once, and the new value appears on `rd_data` one cycle after `rd_addr` selects that register.
- R3: `ret_ready` is 1 only when the oldest slot has completed. A slot allocated with `alloc_wr`=0 counts as completed on allocation. A retirement with `ret_exc`=0 frees the oldest slot and leaves every register unchanged.
- R4: A retirement with `ret_exc`=1 undoes every occupied slot, youngest first. All registers then hold their values from before the oldest slot's instruction, the log is empty, and `alloc_tag` equals the freed head index.
- R5: A flush naming slot `flush_tag` undoes only the slots younger than it. Results of the branch slot and of older slots stay in place, and `alloc_tag` becomes `flush_tag`+1.
- R6: A rewind of N slots holds `busy` high for exactly N cycles, one slot per cycle. A flush with no younger slot raises no busy cycle.
- R7: While `busy` is 1, `alloc_ready` and `ret_ready` are 0 and a completion request is ignored.
- R8: During a rewind, slots that were allocated but never completed are released without writing any register.
- R9: After reset, all registers read 0, the log is empty, `alloc_tag` is 0, `busy` and `ret_ready` are 0, and `alloc_ready` is 1.
- R10: An exception retirement takes priority over a flush, and a flush takes priority over other requests. An allocation, completion or normal retirement presented in the same cycle as an accepted flush or exception has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Request a log slot for a decoded instruction |
| alloc_wr | input | 1 | The instruction writes a destination register |
| alloc_dest | input | 3 | Destination register index |
| alloc_ready | output | 1 | A slot is free and no rewind is running |
| alloc_tag | output | 3 | Slot index the next allocation receives |
| cmp_valid | input | 1 | A result is completing |
| cmp_tag | input | 3 | Slot of the completing instruction |
| cmp_data | input | 16 | Result value |
| ret_valid | input | 1 | Retire the oldest slot |
| ret_exc | input | 1 | The oldest instruction has an exception |
| ret_ready | output | 1 | Oldest slot has completed and the block is idle |
| flush_valid | input | 1 | Branch misprediction: rewind slots younger than `flush_tag` |
| flush_tag | input | 3 | Slot of the mispredicted branch |
| busy | output | 1 | A rewind is in progress |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Registered read data |

## Verification
The assertions check several properties on every cycle. The occupancy never exceeds the slot count. Every busy cycle retires exactly one slot. An exception rewind always ends with the log empty and the pointers equal. Allocation only ever lands in a free slot and advances the tail by one. The two write sources of the register file never collide. Other behaviours can only be shown by the directed scenarios. These are the actual register values after an exception or a branch rewind, the skipping of never-completed slots, the dropping of requests made during busy or in the same cycle as a flush, and wraparound with a full log.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    UW_NONE   = 2'd0,
    UW_EXC    = 2'd1,
    UW_BRANCH = 2'd2
  } unwind_kind_e;
endpackage

// File: rtl/hb_regfile.sv
module hb_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmp_we,
  input  logic [RW-1:0] cmp_addr,
  input  logic [DW-1:0] cmp_data,
  output logic [DW-1:0] cmp_prev,
  input  logic          undo_we,
  input  logic [RW-1:0] undo_addr,
  input  logic [DW-1:0] undo_data,
  input  logic [RW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] regs_q [NREG];

  // value overwritten by the completing result, captured in the same cycle
  assign cmp_prev = regs_q[cmp_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
      rd_data <= '0;
    end else begin
      if (undo_we)     regs_q[undo_addr] <= undo_data;
      else if (cmp_we) regs_q[cmp_addr]  <= cmp_data;
      rd_data <= regs_q[rd_addr];
    end
  end

  // completion and restore come from different controllers and must never meet
  assert_one_writer_R7: assert property (@(posedge clk) disable iff (rst)
    !(undo_we && cmp_we));
endmodule

// File: rtl/hb_slots.sv
module hb_slots #(
  parameter int DEPTH = 8,
  parameter int NREG  = 8,
  parameter int DW    = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_we,
  input  logic [IW-1:0] alloc_idx,
  input  logic [RW-1:0] alloc_dest,
  input  logic          alloc_wr,
  input  logic          cmp_we,
  input  logic [IW-1:0] cmp_idx,
  input  logic [DW-1:0] cmp_old,
  output logic          cmp_ok,
  output logic [RW-1:0] cmp_dest,
  input  logic          free_we,
  input  logic [IW-1:0] free_idx,
  output logic          head_done,
  input  logic          undo_we,
  input  logic [IW-1:0] undo_idx,
  output logic          undo_restore,
  output logic [RW-1:0] undo_dest,
  output logic [DW-1:0] undo_old
);
  logic [DEPTH-1:0] valid_q, done_q, wr_q;
  logic [RW-1:0]    dest_mem [DEPTH];
  logic [DW-1:0]    old_mem  [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[i] <= 1'b0;
        done_q[i]  <= 1'b0;
        wr_q[i]    <= 1'b0;
      end else if (alloc_we && alloc_idx == IW'(i)) begin
        valid_q[i] <= 1'b1;
        done_q[i]  <= !alloc_wr;
        wr_q[i]    <= alloc_wr;
      end else if ((free_we && free_idx == IW'(i)) ||
                   (undo_we && undo_idx == IW'(i))) begin
        valid_q[i] <= 1'b0;
      end else if (cmp_we && cmp_idx == IW'(i)) begin
        done_q[i]  <= 1'b1;
      end
    end
  end

  // payload arrays carry no reset so they map onto plain RAM
  always_ff @(posedge clk) begin
    if (alloc_we) dest_mem[alloc_idx] <= alloc_dest;
    if (cmp_we)   old_mem[cmp_idx]    <= cmp_old;
  end

  assign cmp_ok       = valid_q[cmp_idx] && !done_q[cmp_idx];
  assign cmp_dest     = dest_mem[cmp_idx];
  assign head_done    = valid_q[free_idx] && done_q[free_idx];
  assign undo_restore = undo_we && valid_q[undo_idx] && done_q[undo_idx] && wr_q[undo_idx];
  assign undo_dest    = dest_mem[undo_idx];
  assign undo_old     = old_mem[undo_idx];

  assert_alloc_into_free_R1: assert property (@(posedge clk) disable iff (rst)
    alloc_we |-> !valid_q[alloc_idx]);
  assert_free_only_done_R3: assert property (@(posedge clk) disable iff (rst)
    free_we |-> (valid_q[free_idx] && done_q[free_idx]));
endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import hb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_valid,
  input  logic          cmp_valid,
  input  logic          cmp_ok,
  input  logic          ret_valid,
  input  logic          ret_exc,
  input  logic          head_done,
  input  logic          flush_valid,
  input  logic [IW-1:0] flush_tag,
  output logic          alloc_fire,
  output logic          cmp_fire,
  output logic          free_fire,
  output logic          undo_step,
  output logic [IW-1:0] undo_idx,
  output logic [IW-1:0] head,
  output logic [IW-1:0] tail,
  output logic          alloc_ready,
  output logic          ret_ready,
  output logic          busy
);
  logic [IW-1:0] head_q, tail_q, cursor_q;
  logic [CW-1:0] count_q, left_q;
  logic          busy_q;
  unwind_kind_e  kind_q;

  logic          idle, exc_fire, flush_take, br_start, quiet;
  logic [IW-1:0] younger;

  assign idle        = !busy_q;
  assign alloc_ready = idle && (count_q != CW'(DEPTH));
  assign ret_ready   = idle && (count_q != '0) && head_done;

  assign exc_fire   = ret_valid && ret_ready && ret_exc;
  assign flush_take = idle && flush_valid && !exc_fire && (count_q != '0);
  assign younger    = tail_q - flush_tag - 1'b1;
  assign br_start   = flush_take && (younger != '0);
  assign quiet      = idle && !exc_fire && !flush_valid;

  assign alloc_fire = alloc_valid && alloc_ready && quiet;
  assign cmp_fire   = cmp_valid && cmp_ok && quiet;
  assign free_fire  = ret_valid && ret_ready && !ret_exc && quiet;

  assign undo_step = busy_q;
  assign undo_idx  = cursor_q;
  assign head      = head_q;
  assign tail      = tail_q;
  assign busy      = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q   <= '0;
      tail_q   <= '0;
      cursor_q <= '0;
      count_q  <= '0;
      left_q   <= '0;
      busy_q   <= 1'b0;
      kind_q   <= UW_NONE;
    end else if (busy_q) begin
      cursor_q <= cursor_q - 1'b1;
      tail_q   <= tail_q - 1'b1;
      count_q  <= count_q - 1'b1;
      left_q   <= left_q - 1'b1;
      if (left_q == CW'(1)) begin
        busy_q <= 1'b0;
        kind_q <= UW_NONE;
      end
    end else if (exc_fire) begin
      busy_q   <= 1'b1;
      kind_q   <= UW_EXC;
      left_q   <= count_q;
      cursor_q <= tail_q - 1'b1;
    end else if (br_start) begin
      busy_q   <= 1'b1;
      kind_q   <= UW_BRANCH;
      left_q   <= CW'(younger);
      cursor_q <= tail_q - 1'b1;
    end else begin
      if (alloc_fire) tail_q <= tail_q + 1'b1;
      if (free_fire)  head_q <= head_q + 1'b1;
      count_q <= count_q + CW'(alloc_fire) - CW'(free_fire);
    end
  end

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));
  assert_alloc_order_R1: assert property (@(posedge clk) disable iff (rst)
    alloc_fire |=> tail_q == $past(tail_q) + 1'b1);
  assert_unwind_step_R6: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> count_q == $past(count_q) - 1'b1);
  assert_exc_drains_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && kind_q == UW_EXC && left_q == CW'(1)) |=> (count_q == '0 && tail_q == head_q));
endmodule

// File: rtl/hb_undo_log.sv
module hb_undo_log #(
  parameter int DEPTH = 8,
  parameter int NREG  = 8,
  parameter int DW    = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_valid,
  input  logic          alloc_wr,
  input  logic [RW-1:0] alloc_dest,
  output logic          alloc_ready,
  output logic [IW-1:0] alloc_tag,
  input  logic          cmp_valid,
  input  logic [IW-1:0] cmp_tag,
  input  logic [DW-1:0] cmp_data,
  input  logic          ret_valid,
  input  logic          ret_exc,
  output logic          ret_ready,
  input  logic          flush_valid,
  input  logic [IW-1:0] flush_tag,
  output logic          busy,
  input  logic [RW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic          alloc_fire, cmp_fire, free_fire, undo_step;
  logic          cmp_ok, head_done, undo_restore;
  logic [IW-1:0] undo_idx, head, tail;
  logic [RW-1:0] cmp_dest, undo_dest;
  logic [DW-1:0] cmp_prev, undo_old;

  assign alloc_tag = tail;

  hb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .cmp_valid(cmp_valid), .cmp_ok(cmp_ok),
    .ret_valid(ret_valid), .ret_exc(ret_exc), .head_done(head_done),
    .flush_valid(flush_valid), .flush_tag(flush_tag),
    .alloc_fire(alloc_fire), .cmp_fire(cmp_fire), .free_fire(free_fire),
    .undo_step(undo_step), .undo_idx(undo_idx), .head(head), .tail(tail),
    .alloc_ready(alloc_ready), .ret_ready(ret_ready), .busy(busy)
  );

  hb_slots #(.DEPTH(DEPTH), .NREG(NREG), .DW(DW)) u_slots (
    .clk(clk), .rst(rst),
    .alloc_we(alloc_fire), .alloc_idx(tail), .alloc_dest(alloc_dest), .alloc_wr(alloc_wr),
    .cmp_we(cmp_fire), .cmp_idx(cmp_tag), .cmp_old(cmp_prev),
    .cmp_ok(cmp_ok), .cmp_dest(cmp_dest),
    .free_we(free_fire), .free_idx(head), .head_done(head_done),
    .undo_we(undo_step), .undo_idx(undo_idx),
    .undo_restore(undo_restore), .undo_dest(undo_dest), .undo_old(undo_old)
  );

  hb_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk(clk), .rst(rst),
    .cmp_we(cmp_fire), .cmp_addr(cmp_dest), .cmp_data(cmp_data), .cmp_prev(cmp_prev),
    .undo_we(undo_restore), .undo_addr(undo_dest), .undo_data(undo_old),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/hb_undo_log_tb.sv
`timescale 1ns/100ps
module hb_undo_log_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        alloc_valid = 1'b0, alloc_wr = 1'b0;
  logic [2:0]  alloc_dest = '0;
  logic        alloc_ready;
  logic [2:0]  alloc_tag;
  logic        cmp_valid = 1'b0;
  logic [2:0]  cmp_tag = '0;
  logic [15:0] cmp_data = '0;
  logic        ret_valid = 1'b0, ret_exc = 1'b0, ret_ready;
  logic        flush_valid = 1'b0;
  logic [2:0]  flush_tag = '0;
  logic        busy;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  hb_undo_log u_dut (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_wr(alloc_wr), .alloc_dest(alloc_dest),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data),
    .ret_valid(ret_valid), .ret_exc(ret_exc), .ret_ready(ret_ready),
    .flush_valid(flush_valid), .flush_tag(flush_tag), .busy(busy),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic alloc_op(input logic [2:0] d, input logic w, input logic [2:0] exp_tag);
    @(negedge clk);
    chk("R1 alloc tag", {29'd0, alloc_tag}, {29'd0, exp_tag});
    alloc_valid = 1'b1; alloc_wr = w; alloc_dest = d;
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic cmp_op(input logic [2:0] t, input logic [15:0] v);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_tag = t; cmp_data = v;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  task automatic retire_ok();
    @(negedge clk);
    chk("R3 ret_ready before retire", {31'd0, ret_ready}, 32'd1);
    ret_valid = 1'b1; ret_exc = 1'b0;
    @(negedge clk);
    ret_valid = 1'b0;
  endtask

  task automatic read_reg(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic test_reset();
    logic [15:0] v;
    chk("R9 busy", {31'd0, busy}, 32'd0);
    chk("R9 alloc_ready", {31'd0, alloc_ready}, 32'd1);
    chk("R9 ret_ready", {31'd0, ret_ready}, 32'd0);
    chk("R9 alloc_tag", {29'd0, alloc_tag}, 32'd0);
    for (int r = 0; r < 8; r++) begin
      read_reg(3'(r), v);
      chk("R9 register zero", {16'd0, v}, 32'd0);
    end
  endtask

  task automatic test_normal();
    logic [15:0] v;
    alloc_op(3'd1, 1'b1, 3'd0);
    alloc_op(3'd2, 1'b1, 3'd1);
    alloc_op(3'd3, 1'b1, 3'd2);
    @(negedge clk);
    chk("R3 ret_ready low while head pending", {31'd0, ret_ready}, 32'd0);
    cmp_op(3'd1, 16'h1111);
    cmp_op(3'd0, 16'hAAAA);
    cmp_op(3'd2, 16'h3333);
    read_reg(3'd1, v); chk("R2 r1 new value", {16'd0, v}, 32'hAAAA);
    read_reg(3'd2, v); chk("R2 r2 new value", {16'd0, v}, 32'h1111);
    read_reg(3'd3, v); chk("R2 r3 new value", {16'd0, v}, 32'h3333);
    retire_ok(); retire_ok(); retire_ok();
    @(negedge clk);
    chk("R3 ret_ready after drain", {31'd0, ret_ready}, 32'd0);
    read_reg(3'd1, v); chk("R3 r1 kept", {16'd0, v}, 32'hAAAA);
    read_reg(3'd3, v); chk("R3 r3 kept", {16'd0, v}, 32'h3333);
  endtask

  task automatic test_exception();
    logic [15:0] v;
    int n;
    alloc_op(3'd1, 1'b1, 3'd3);
    alloc_op(3'd2, 1'b1, 3'd4);
    alloc_op(3'd1, 1'b1, 3'd5);
    alloc_op(3'd4, 1'b1, 3'd6);
    alloc_op(3'd0, 1'b0, 3'd7);
    cmp_op(3'd3, 16'h0A01);
    cmp_op(3'd4, 16'h0B02);
    cmp_op(3'd5, 16'h0C03);
    read_reg(3'd1, v); chk("R2 r1 youngest value", {16'd0, v}, 32'h0C03);
    @(negedge clk);
    ret_valid = 1'b1; ret_exc = 1'b1;
    @(negedge clk);
    ret_valid = 1'b0; ret_exc = 1'b0;
    chk("R6 busy after exception", {31'd0, busy}, 32'd1);
    chk("R7 alloc_ready during busy", {31'd0, alloc_ready}, 32'd0);
    chk("R7 ret_ready during busy", {31'd0, ret_ready}, 32'd0);
    cmp_valid = 1'b1; cmp_tag = 3'd6; cmp_data = 16'hDDDD;
    n = 1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      cmp_valid = 1'b0;
      if (!busy) break;
      n++;
    end
    chk("R6 exception rewind cycles", n, 32'd5);
    read_reg(3'd1, v); chk("R4 r1 restored", {16'd0, v}, 32'hAAAA);
    read_reg(3'd2, v); chk("R4 r2 restored", {16'd0, v}, 32'h1111);
    read_reg(3'd4, v); chk("R8 R7 r4 untouched", {16'd0, v}, 32'h0000);
    @(negedge clk);
    chk("R4 tail back at head", {29'd0, alloc_tag}, 32'd3);
    chk("R4 log empty", {31'd0, ret_ready}, 32'd0);
  endtask

  task automatic test_branch();
    logic [15:0] v;
    int n;
    alloc_op(3'd5, 1'b1, 3'd3);
    alloc_op(3'd0, 1'b0, 3'd4);
    alloc_op(3'd5, 1'b1, 3'd5);
    alloc_op(3'd6, 1'b1, 3'd6);
    cmp_op(3'd3, 16'h5050);
    cmp_op(3'd5, 16'h5151);
    cmp_op(3'd6, 16'h6060);
    @(negedge clk);
    flush_valid = 1'b1; flush_tag = 3'd4;
    alloc_valid = 1'b1; alloc_wr = 1'b1; alloc_dest = 3'd7;
    @(negedge clk);
    flush_valid = 1'b0; alloc_valid = 1'b0;
    n = 0;
    for (int k = 0; k < 40; k++) begin
      if (!busy) break;
      n++;
      @(negedge clk);
    end
    chk("R6 branch rewind cycles", n, 32'd2);
    chk("R5 R10 tail after flush", {29'd0, alloc_tag}, 32'd5);
    read_reg(3'd5, v); chk("R5 r5 older result kept", {16'd0, v}, 32'h5050);
    read_reg(3'd6, v); chk("R5 r6 restored", {16'd0, v}, 32'h0000);
    retire_ok(); retire_ok();
    alloc_op(3'd7, 1'b1, 3'd5);
    cmp_op(3'd5, 16'h7777);
    @(negedge clk);
    flush_valid = 1'b1; flush_tag = 3'd5;
    @(negedge clk);
    flush_valid = 1'b0;
    chk("R6 no busy with nothing younger", {31'd0, busy}, 32'd0);
    chk("R6 tail kept", {29'd0, alloc_tag}, 32'd6);
    read_reg(3'd7, v); chk("R5 r7 kept", {16'd0, v}, 32'h7777);
    retire_ok();
  endtask

  task automatic test_full();
    for (int k = 0; k < 8; k++) alloc_op(3'd0, 1'b0, 3'(6 + k));
    @(negedge clk);
    chk("R1 alloc_ready when full", {31'd0, alloc_ready}, 32'd0);
    alloc_valid = 1'b1; alloc_wr = 1'b0;
    @(negedge clk);
    alloc_valid = 1'b0;
    chk("R1 tag unchanged when full", {29'd0, alloc_tag}, 32'd6);
    retire_ok();
    @(negedge clk);
    chk("R1 alloc_ready after free", {31'd0, alloc_ready}, 32'd1);
    for (int k = 0; k < 7; k++) retire_ok();
    @(negedge clk);
    chk("R3 empty after full drain", {31'd0, ret_ready}, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_normal();
    test_exception();
    test_branch();
    test_full();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule